// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter running one channel per start. Software reaches it through a small register window: one control/status word and four read-only result words. A conversion begins on a software write of the start bit or on a rising edge of an external trigger input. The block then drives a channel select and a trial DAC code towards the analog front end, reads back a single comparator bit, and settles one result bit per step from the most significant bit down.

When the search ends, the code goes to the result word picked by the two low channel-select bits. The start bit drops, a done flag rises, and a level interrupt follows the done flag when interrupts are enabled. Clearing the start bit while a conversion runs stops it at once and keeps the previous results. The done flag can only be cleared by reading the status word while the flag is set and then writing a 0 to it.

The conversion engine is a three-state machine. `ENG_IDLE` goes to `ENG_TRIAL` on an accepted start. `ENG_TRIAL` stays put for `RES_BITS` steps of `STEP_DIV` cycles each. It goes back to `ENG_IDLE` on an abort, or on to `ENG_DONE` when the last bit is settled. `ENG_DONE` lasts one cycle, stores the result and always returns to `ENG_IDLE`.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the status word, all four result words, `irq` and `dac_code` read 0.
- R2: Status word address 4 has these fields: bit 0 start, bit 1 done, bit 2 interrupt enable, bits 7:4 channel. Writing 1 to the start bit while it is 0 starts a conversion in the same cycle. The start bit reads 1 until the conversion ends. During step k (k = 0 to 9, each step `STEP_DIV` = 4 cycles), `dac_code` shows the bits already kept OR'ed with the one-hot trial bit 9-k. Outside a conversion, `dac_code` is 0.
- R3: At the last cycle of each step, the trial bit is kept when `cmp_ge` is 1 (input at or above the trial code). For inputs 0 to 1023, the final code equals the input.
- R4: One cycle after the tenth step, the code is written to result word ch[1:0] (addresses 0 to 3, right-justified in bits 9:0). In the same cycle the start bit clears and the done flag sets. Channel 9 (ch = 1001) therefore lands in word 1.
- R5: A rising edge on `ext_trig` while idle starts a conversion on the channel held in the status word.
- R6: A start write or trigger edge while a conversion runs is ignored. Timing, channel and result are unchanged.
- R7: Writing 0 to the start bit during a conversion halts it. The start bit reads 0 the next cycle and `dac_code` returns to 0. No result word and no done flag change.
- R8: A status write with done bit 0 clears the done flag only if the status word was read while done was 1 since the flag last cleared. Writing 1 to the done bit has no effect.
- R9: `irq` equals done AND interrupt enable.
- R10: `chan_sel` shows the channel captured at start and holds it until the next start. A write that sets start and changes the channel uses the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms done-flag clearing) |
| bus_addr | input | 3 | Word address: 0-3 results, 4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| ext_trig | input | 1 | External start, rising edge |
| cmp_ge | input | 1 | Comparator: input at or above `dac_code` |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 4 | Channel select to the analog mux |
| irq | output | 1 | Level interrupt request |

## Verification
The bench model has its own comparator. Analog levels per channel cover 0, 1, 512, 1023 and mixed patterns such as 682 and 777. The extremes show whether every bit is rejected or every bit kept, and the alternating pattern shows that bits are tested in MSB-to-LSB order. Conversions go to all four result words, including channel 9 into word 1, which shows that only the low channel bits pick the word. Starts by write and by trigger, overlapping starts, an abort mid-search and done clears with and without the prior read each separate a distinct control path.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_TRIAL = 2'd1,
        ENG_DONE  = 2'd2
    } eng_state_t;

    localparam int GO_BIT   = 0;
    localparam int DONE_BIT = 1;
    localparam int IE_BIT   = 2;
    localparam int CH_LSB   = 4;
endpackage

// File: rtl/sar_adc_engine.sv
module sar_adc_engine
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CH_W     = 4,
    parameter int STEP_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                abort_req,
    input  logic                cmp_ge,
    input  logic [CH_W-1:0]     chan_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_W-1:0]     chan_sel,
    output logic                conv_done,
    output logic [RES_BITS-1:0] conv_result
);
    localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);
    localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

    eng_state_t          state_q, state_d;
    logic [RES_BITS-1:0] sar_q, mask_q;
    logic [DIV_W-1:0]    div_q;
    logic [CH_W-1:0]     chan_q;
    logic                step_end;

    assign step_end = (div_q == DIV_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start_req) state_d = ENG_TRIAL;
            ENG_TRIAL: begin
                if (abort_req)                 state_d = ENG_IDLE;
                else if (step_end && mask_q[0]) state_d = ENG_DONE;
            end
            ENG_DONE:  state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q  <= '0;
            mask_q <= '0;
            div_q  <= '0;
            chan_q <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start_req) begin
                        sar_q  <= '0;
                        mask_q <= MSB_MASK;
                        div_q  <= '0;
                        chan_q <= chan_in;
                    end
                end
                ENG_TRIAL: begin
                    if (abort_req) begin
                        mask_q <= '0;
                        div_q  <= '0;
                    end else if (step_end) begin
                        div_q  <= '0;
                        mask_q <= mask_q >> 1;
                        if (cmp_ge) sar_q <= sar_q | mask_q;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: begin
                    mask_q <= '0;
                    div_q  <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dac_code    = (state_q == ENG_TRIAL) ? (sar_q | mask_q) : '0;
        conv_done   = (state_q == ENG_DONE);
        conv_result = sar_q;
        chan_sel    = chan_q;
    end

    // R2
    trial_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_TRIAL) |-> ($countones(mask_q) == 1));

    // R3
    keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_TRIAL && step_end && cmp_ge && !abort_req)
        |=> ((sar_q & $past(mask_q)) != '0));

    // R10
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_IDLE) |=> $stable(chan_q));
endmodule

// File: rtl/sar_adc_results.sv
module sar_adc_results #(
    parameter int RES_BITS = 10,
    parameter int NUM_RES  = 4,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [RES_BITS-1:0] wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [RES_BITS-1:0] rd_data
);
    logic [RES_BITS-1:0] res_q [NUM_RES];

    for (genvar g = 0; g < NUM_RES; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               res_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))    res_q[g] <= wr_data;
        end
    end

    assign rd_data = res_q[rd_idx];

    // R4
    result_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (res_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int CH_W     = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int CSR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ext_trig,
    input  logic              conv_done,
    output logic              start_fire,
    output logic              abort_req,
    output logic [CH_W-1:0]   chan_next,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              irq_o
);
    logic            go_q, done_q, ie_q, armed_q, trig_q;
    logic [CH_W-1:0] ch_q;
    logic            csr_wr, csr_rd, trig_rise, done_clear;
    logic            unused_wbits;

    assign csr_wr     = bus_sel && bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));
    assign csr_rd     = bus_sel && bus_rd && (bus_addr == ADDR_W'(CSR_ADDR));
    assign trig_rise  = ext_trig && !trig_q;
    assign start_fire = !go_q && ((csr_wr && bus_wdata[GO_BIT]) || trig_rise);
    assign abort_req  = go_q && csr_wr && !bus_wdata[GO_BIT] && !conv_done;
    assign done_clear = csr_wr && !bus_wdata[DONE_BIT] && armed_q;
    assign chan_next  = csr_wr ? bus_wdata[CH_LSB +: CH_W] : ch_q;
    assign unused_wbits = ^{bus_wdata[DATA_W-1:CH_LSB+CH_W], bus_wdata[CH_LSB-1:IE_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            ie_q    <= 1'b0;
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
            ch_q    <= '0;
        end else begin
            trig_q <= ext_trig;
            if (conv_done)       go_q <= 1'b0;
            else if (start_fire) go_q <= 1'b1;
            else if (abort_req)  go_q <= 1'b0;

            if (conv_done) begin
                done_q <= 1'b1;
            end else if (done_clear) begin
                done_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (csr_rd && done_q) begin
                armed_q <= 1'b1;
            end

            if (csr_wr) begin
                ie_q <= bus_wdata[IE_BIT];
                ch_q <= bus_wdata[CH_LSB +: CH_W];
            end
        end
    end

    always_comb begin
        csr_rdata                  = '0;
        csr_rdata[GO_BIT]          = go_q;
        csr_rdata[DONE_BIT]        = done_q;
        csr_rdata[IE_BIT]          = ie_q;
        csr_rdata[CH_LSB +: CH_W]  = ch_q;
        irq_o                      = done_q && ie_q;
    end

    // R4
    complete_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (done_q && !go_q));

    // R7
    abort_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !go_q);

    // R8
    done_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !armed_q && !conv_done) |=> done_q);

    // R6
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && !conv_done && !abort_req) |=> go_q);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CH_W     = 4,
    parameter int NUM_RES  = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16,
    parameter int STEP_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ext_trig,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_W-1:0]     chan_sel,
    output logic                irq
);
    localparam int IDX_W    = $clog2(NUM_RES);
    localparam int CSR_ADDR = NUM_RES;

    logic                start_fire, abort_req, conv_done;
    logic [CH_W-1:0]     chan_next;
    logic [DATA_W-1:0]   csr_rdata;
    logic [RES_BITS-1:0] conv_result, res_rd;

    sar_adc_regs #(
        .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ext_trig(ext_trig), .conv_done(conv_done),
        .start_fire(start_fire), .abort_req(abort_req),
        .chan_next(chan_next), .csr_rdata(csr_rdata), .irq_o(irq)
    );

    sar_adc_engine #(
        .RES_BITS(RES_BITS), .CH_W(CH_W), .STEP_DIV(STEP_DIV)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_fire), .abort_req(abort_req), .cmp_ge(cmp_ge),
        .chan_in(chan_next), .dac_code(dac_code), .chan_sel(chan_sel),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    sar_adc_results #(
        .RES_BITS(RES_BITS), .NUM_RES(NUM_RES), .IDX_W(IDX_W)
    ) u_results (
        .clk(clk), .rst_n(rst_n),
        .wr_en(conv_done), .wr_idx(chan_sel[IDX_W-1:0]), .wr_data(conv_result),
        .rd_idx(bus_addr[IDX_W-1:0]), .rd_data(res_rd)
    );

    always_comb begin
        if (bus_addr < ADDR_W'(NUM_RES))        bus_rdata = DATA_W'(res_rd);
        else if (bus_addr == ADDR_W'(CSR_ADDR)) bus_rdata = csr_rdata;
        else                                    bus_rdata = '0;
    end
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        cmp_ge;
    logic [9:0]  dac_code;
    logic [3:0]  chan_sel;
    logic        irq;

    int vin [16];
    int errors = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sar_adc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_trig(ext_trig), .cmp_ge(cmp_ge), .dac_code(dac_code),
        .chan_sel(chan_sel), .irq(irq)
    );

    // comparator model
    assign cmp_ge = (vin[chan_sel] >= int'(dac_code));

    // reference model
    int m_state, m_n, m_sar, m_run_ch, m_ch;
    bit m_go, m_done, m_ie, m_arm, m_trig;
    int m_res [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_n = 0; m_sar = 0; m_run_ch = 0; m_ch = 0;
            m_go = 0; m_done = 0; m_ie = 0; m_arm = 0; m_trig = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            bit csr_w, csr_r, fin, fire, abrt;
            csr_w = bus_sel && bus_wr && bus_addr == 3'd4;
            csr_r = bus_sel && bus_rd && bus_addr == 3'd4;
            fin   = (m_state == 2);
            fire  = !m_go && ((csr_w && bus_wdata[0]) || (ext_trig && !m_trig));
            abrt  = m_go && csr_w && !bus_wdata[0] && !fin;
            if (fin) begin
                m_res[m_run_ch % 4] = m_sar;
                m_done = 1; m_go = 0; m_state = 0;
            end else if (csr_w && !bus_wdata[1] && m_arm) begin
                m_done = 0; m_arm = 0;
            end else if (csr_r && m_done) begin
                m_arm = 1;
            end
            if (m_state == 1) begin
                if (abrt) begin
                    m_state = 0; m_go = 0;
                end else begin
                    m_n++;
                    if (m_n % D == 0) begin
                        int trial;
                        trial = m_sar | (1 << (10 - m_n / D));
                        if (vin[m_run_ch] >= trial) m_sar = trial;
                        if (m_n == 10 * D) m_state = 2;
                    end
                end
            end
            if (fire) begin
                m_go = 1; m_state = 1; m_n = 0; m_sar = 0;
                m_run_ch = csr_w ? int'(bus_wdata[7:4]) : m_ch;
            end
            if (csr_w) begin
                m_ie = bus_wdata[2];
                m_ch = int'(bus_wdata[7:4]);
            end
            m_trig = ext_trig;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        if (bus_addr < 3'd4) return m_res[bus_addr];
        if (bus_addr == 3'd4)
            return (m_ch << 4) | (int'(m_ie) << 2) | (int'(m_done) << 1) | int'(m_go);
        return 0;
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk("R2 start bit", int'(bus_rdata[0] && bus_addr == 3'd4) | int'(bus_addr != 3'd4 && m_go),
                int'(m_go));
            chk("R3 dac_code", int'(dac_code),
                (m_state == 1) ? (m_sar | (1 << (9 - m_n / D))) : 0);
            chk("R4 read data", int'(bus_rdata), exp_rdata());
            chk("R9 irq", int'(irq), int'(m_done && m_ie));
            chk("R10 chan_sel", int'(chan_sel), m_run_ch);
        end
    end

    task automatic wr_csr(logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_reg(logic [2:0] a);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic settle();
        repeat (50) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); ext_trig = 1;
        repeat (3) @(negedge clk);
        ext_trig = 0;
    endtask

    initial begin
        foreach (vin[i]) vin[i] = 0;
        vin[9] = 682; vin[0] = 0; vin[6] = 1023; vin[11] = 512;
        vin[5] = 1; vin[2] = 300; vin[3] = 777; vin[1] = 100;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(bus_rdata), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 dac", int'(dac_code), 0);

        // R2 R4 channel 9 with interrupt enable
        wr_csr(16'h0095);
        chk("R2 first trial", int'(dac_code), 512);
        chk("R2 busy", int'(bus_rdata[0]), 1);
        settle();
        rd_reg(3'd1);
        chk("R4 word B", int'(bus_rdata), 682);
        chk("R9 irq set", int'(irq), 1);

        // R8 clear without prior read is ignored, then proper sequence
        wr_csr(16'h0094);
        chk("R8 no-arm keep", int'(bus_rdata[1]), 1);
        rd_reg(3'd4);
        wr_csr(16'h0094);
        chk("R8 cleared", int'(bus_rdata[1]), 0);
        chk("R9 irq clear", int'(irq), 0);
        wr_csr(16'h0096);
        chk("R8 write one", int'(bus_rdata[1]), 0);

        // R3 extremes and mid-scale on other words
        wr_csr(16'h0007); settle(); rd_reg(3'd0); chk("R3 zero", int'(bus_rdata), 0);
        wr_csr(16'h0067); settle(); rd_reg(3'd2); chk("R3 full", int'(bus_rdata), 1023);
        wr_csr(16'h00B7); settle(); rd_reg(3'd3); chk("R3 mid", int'(bus_rdata), 512);
        wr_csr(16'h0057); settle(); rd_reg(3'd1); chk("R3 one", int'(bus_rdata), 1);

        // R5 trigger start on channel 2
        wr_csr(16'h0026);
        pulse_trig();
        chk("R5 trig busy", int'(chan_sel), 2);
        settle(); rd_reg(3'd2); chk("R5 trig result", int'(bus_rdata), 300);

        // R6 overlapping start and trigger ignored
        wr_csr(16'h0037);
        repeat (10) @(negedge clk);
        wr_csr(16'h0007);
        pulse_trig();
        chk("R6 channel kept", int'(chan_sel), 3);
        settle(); rd_reg(3'd3); chk("R6 result", int'(bus_rdata), 777);

        // R7 abort mid conversion
        wr_csr(16'h0017);
        repeat (15) @(negedge clk);
        wr_csr(16'h0016);
        chk("R7 halted", int'(bus_rdata[0]), 0);
        chk("R7 dac idle", int'(dac_code), 0);
        settle(); rd_reg(3'd1); chk("R7 word kept", int'(bus_rdata), 1);

        // R9 enable off with done set
        wr_csr(16'h0012);
        chk("R9 masked", int'(irq), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule